// File: doc/BRIEF.md
# Super I/O Configuration Register Unit

This block holds the setup state of a legacy peripheral chip and turns it into resource assignments for the functions that chip contains. The host reaches it through a two-byte window on a byte-wide strobe bus. An even byte address in the window is the index port, which chooses one of the configuration registers. An odd byte address is the data port, which reads or writes the chosen register. There are three registers: function enable, function address and power/test. The index port also gives an identification sequence, so that probing software can tell the chip is present.

On reset the three registers load from reset tables. A 5-bit strap input picks the table entry. The enables, I/O base addresses and IRQ numbers are then decoded combinationally from the registers and go out at once. The outputs cover a parallel port, two UARTs, a floppy controller and an IDE controller. When a data write is accepted, a one-cycle update pulse tells the peripherals that they must take up the new settings.

The identification logic is a three-state machine. Its states are `ID_FIRST` (after reset), `ID_SECOND` and `ID_DONE`. The transitions are:
- `ID_FIRST` → `ID_SECOND` on an index read.
- `ID_FIRST` → `ID_DONE` on an index write.
- `ID_SECOND` → `ID_DONE` on an index read or an index write.
- `ID_DONE` stays in `ID_DONE` until reset.

Top module: `sio_cfg_unit`

## Requirements
- R1: An access lies in the window when address bits [15:1] equal those of `WIN_BASE` (0x398 by default). Bit 0 = 0 selects the index port and bit 0 = 1 selects the data port. A strobe outside the window has no effect.
- R2: After reset, the first index-port read returns 0x88, the second returns 0x00, and every later read returns the selected index. An index-port write ends this sequence at once.
- R3: Reset sets the selected index to 0 and restarts the identification sequence. It loads the registers from the strap-indexed tables: strap 1 gives enable=0x4F, address=0x11, power/test=0x00, and strap 31 gives 0x00, 0x10, 0x02.
- R4: Index 0 is the enable register, index 1 the address register and index 2 the power/test register. With an index of 3 or more, a data write is ignored and a data read returns 0x00.
- R5: The enable register bits map as follows: bit0 parallel, bit1 UART 0, bit2 UART 1, bit3 floppy, bit4 floppy four-drive. Each of these outputs equals its bit.
- R6: Address bits [1:0] set the parallel base: 0→0x378, 1→0x3BC, 2→0x278, 3→0 (IRQ 0). The IRQ is 7 for code 1 and 5 for code 2. For code 0 it is 7 when power/test bit 3 is set and 5 otherwise.
- R7: UART n takes the code in address bits [2n+3:2n+2]. Code 0 gives 0x3F8 and code 1 gives 0x2F8. Code 2 indexes {0x3E8,0x338,0x2E8,0x220} and code 3 indexes {0x2E8,0x238,0x2E0,0x228}, both by address bits [7:6]. The IRQ is 3 for an odd code and 4 for an even code.
- R8: The floppy base is 0x370 when enable bit5 is set and 0x3F0 otherwise, with IRQ 6. IDE is enabled by enable bit6. Its base is 0x170 when bit7 is set and 0x1F0 otherwise, its alternate address is the base plus 0x206, and its IRQ is 14.
- R9: `cfg_upd` is high for exactly the one cycle after an accepted data write (index below 3), and never after an ignored write.
- R10: Read data is registered and valid one cycle after the rising edge of the read strobe. It changes at no other time. A strobe held for several cycles acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 5 | Reset-table selector |
| bus_addr | input | IOA_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_upd | output | 1 | One-cycle reconfiguration pulse |
| par_en | output | 1 | Parallel port enable |
| par_base | output | IOA_W | Parallel port base |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | UART enables |
| uart_base | output | 2×IOA_W | UART bases |
| uart_irq | output | 2×4 | UART IRQs |
| fdc_en | output | 1 | Floppy enable |
| fdc_quad | output | 1 | Floppy four-drive mode |
| fdc_base | output | IOA_W | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | IOA_W | IDE base |
| ide_alt | output | IOA_W | IDE alternate status address |
| ide_irq | output | 4 | IDE IRQ |

## Verification
The checker runs on every cycle and covers these rules:
- The update pulse never lasts two cycles.
- An enable output never changes without an update pulse.
- Read data changes only after a read strobe.
- Every UART IRQ is 3 or 4.
- The parallel port at 0x3BC uses IRQ 7.

Other behaviour needs the bench's scenarios:
- The identification byte order, and a held strobe advancing the sequence only once.
- The strap-selected reset contents.
- Ignored writes through indices of 3 or more.
- The full decode tables, swept over all 256 address-register values with both values of the IRQ-select bit, and over all 256 enable values.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        ID_FIRST  = 2'd0,
        ID_SECOND = 2'd1,
        ID_DONE   = 2'd2
    } id_state_t;

    localparam int        REG_CNT  = 3;
    localparam logic [7:0] ID_BYTE = 8'h88;

    // Reset value of the enable register for a strap code
    function automatic logic [7:0] strap_en(input logic [4:0] s);
        logic [7:0] v;
        if (s <= 5'd5)       v = 8'h4F;
        else if (s <= 5'd11) v = 8'h4B;
        else if (s <= 5'd15) v = 8'h0F;
        else if (s <= 5'd19) v = 8'h49;
        else if (s <= 5'd23) v = 8'h07;
        else if (s <= 5'd29) v = 8'h47;
        else if (s == 5'd30) v = 8'h08;
        else                 v = 8'h00;
        return v;
    endfunction

    // Reset value of the address register for a strap code
    function automatic logic [7:0] strap_addr(input logic [4:0] s);
        logic [7:0] v;
        unique case (s)
            5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: v = 8'h10;
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  v = 8'h11;
            5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
            5'd5, 5'd29:                             v = 8'h38;
            5'd6, 5'd16, 5'd19:                      v = 8'h00;
            5'd7, 5'd8, 5'd17, 5'd18:                v = 8'h01;
            5'd9:                                    v = 8'h09;
            default:                                 v = 8'h08;
        endcase
        return v;
    endfunction

    // Reset value of the power/test register for a strap code
    function automatic logic [7:0] strap_pwr(input logic [4:0] s);
        return (s == 5'd31) ? 8'h02 : 8'h00;
    endfunction

endpackage

// File: rtl/sio_cfg_index.sv
module sio_cfg_index
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_rd,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic [7:0] sel_idx,
    output logic [7:0] idx_rdata
);

    id_state_t  state_q, state_d;
    logic [7:0] sel_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ID_FIRST;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ID_FIRST: begin
                if (idx_wr)      state_d = ID_DONE;
                else if (idx_rd) state_d = ID_SECOND;
            end
            ID_SECOND: begin
                if (idx_wr || idx_rd) state_d = ID_DONE;
            end
            ID_DONE:  state_d = ID_DONE;
            default:  state_d = ID_DONE;
        endcase
    end

    // outputs: value an index read returns in the current state
    always_comb begin
        unique case (state_q)
            ID_FIRST:  idx_rdata = ID_BYTE;
            ID_SECOND: idx_rdata = 8'h00;
            default:   idx_rdata = sel_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= 8'h00;
        else if (idx_wr) sel_q <= wdata;
    end

    assign sel_idx = sel_q;

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] strap,
    input  logic       dat_wr,
    input  logic [7:0] sel_idx,
    input  logic [7:0] wdata,
    output logic       accept,
    output logic [7:0] en_reg,
    output logic [7:0] addr_reg,
    output logic [7:0] pwr_reg,
    output logic [7:0] dat_rdata
);

    logic [7:0] regs_q [REG_CNT];
    logic       idx_ok;

    assign idx_ok = (sel_idx < 8'(REG_CNT));
    assign accept = dat_wr && idx_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q[0] <= strap_en(strap);
            regs_q[1] <= strap_addr(strap);
            regs_q[2] <= strap_pwr(strap);
        end else if (accept) begin
            regs_q[sel_idx[1:0]] <= wdata;
        end
    end

    assign dat_rdata = idx_ok ? regs_q[sel_idx[1:0]] : 8'h00;
    assign en_reg    = regs_q[0];
    assign addr_reg  = regs_q[1];
    assign pwr_reg   = regs_q[2];

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode #(
    parameter int IOA_W = 16
) (
    input  logic [7:0]                  en_reg,
    input  logic [7:0]                  addr_reg,
    input  logic                        par_irq_hi,
    output logic                        par_en,
    output logic [IOA_W-1:0]            par_base,
    output logic [3:0]                  par_irq,
    output logic [1:0]                  uart_en,
    output logic [1:0][IOA_W-1:0]       uart_base,
    output logic [1:0][3:0]             uart_irq,
    output logic                        fdc_en,
    output logic                        fdc_quad,
    output logic [IOA_W-1:0]            fdc_base,
    output logic [3:0]                  fdc_irq,
    output logic                        ide_en,
    output logic [IOA_W-1:0]            ide_base,
    output logic [IOA_W-1:0]            ide_alt,
    output logic [3:0]                  ide_irq
);

    localparam int UART_N = 2;

    assign par_en   = en_reg[0];
    assign uart_en  = en_reg[2:1];
    assign fdc_en   = en_reg[3];
    assign fdc_quad = en_reg[4];
    assign ide_en   = en_reg[6];

    always_comb begin
        unique case (addr_reg[1:0])
            2'd0: begin par_base = IOA_W'(16'h0378); par_irq = par_irq_hi ? 4'd7 : 4'd5; end
            2'd1: begin par_base = IOA_W'(16'h03BC); par_irq = 4'd7; end
            2'd2: begin par_base = IOA_W'(16'h0278); par_irq = 4'd5; end
            default: begin par_base = '0; par_irq = 4'd0; end
        endcase
    end

    for (genvar n = 0; n < UART_N; n++) begin : g_uart
        logic [1:0] code;
        assign code = addr_reg[2*n+3:2*n+2];
        always_comb begin
            unique case (code)
                2'd0: uart_base[n] = IOA_W'(16'h03F8);
                2'd1: uart_base[n] = IOA_W'(16'h02F8);
                2'd2: begin
                    unique case (addr_reg[7:6])
                        2'd0: uart_base[n] = IOA_W'(16'h03E8);
                        2'd1: uart_base[n] = IOA_W'(16'h0338);
                        2'd2: uart_base[n] = IOA_W'(16'h02E8);
                        default: uart_base[n] = IOA_W'(16'h0220);
                    endcase
                end
                default: begin
                    unique case (addr_reg[7:6])
                        2'd0: uart_base[n] = IOA_W'(16'h02E8);
                        2'd1: uart_base[n] = IOA_W'(16'h0238);
                        2'd2: uart_base[n] = IOA_W'(16'h02E0);
                        default: uart_base[n] = IOA_W'(16'h0228);
                    endcase
                end
            endcase
        end
        assign uart_irq[n] = code[0] ? 4'd3 : 4'd4;
    end

    assign fdc_base = en_reg[5] ? IOA_W'(16'h0370) : IOA_W'(16'h03F0);
    assign fdc_irq  = 4'd6;
    assign ide_base = en_reg[7] ? IOA_W'(16'h0170) : IOA_W'(16'h01F0);
    assign ide_alt  = ide_base + IOA_W'(16'h0206);
    assign ide_irq  = 4'd14;

endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit #(
    parameter int               IOA_W    = 16,
    parameter logic [IOA_W-1:0] WIN_BASE = IOA_W'(16'h0398)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [4:0]            strap,
    input  logic [IOA_W-1:0]      bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cfg_upd,
    output logic                  par_en,
    output logic [IOA_W-1:0]      par_base,
    output logic [3:0]            par_irq,
    output logic [1:0]            uart_en,
    output logic [1:0][IOA_W-1:0] uart_base,
    output logic [1:0][3:0]       uart_irq,
    output logic                  fdc_en,
    output logic                  fdc_quad,
    output logic [IOA_W-1:0]      fdc_base,
    output logic [3:0]            fdc_irq,
    output logic                  ide_en,
    output logic [IOA_W-1:0]      ide_base,
    output logic [IOA_W-1:0]      ide_alt,
    output logic [3:0]            ide_irq
);

    logic       hit, rd_q, wr_q, rd_go, wr_go;
    logic       idx_rd, idx_wr, dat_wr, accept;
    logic [7:0] sel_idx, idx_rdata, dat_rdata;
    logic [7:0] en_reg, addr_reg, pwr_reg;
    logic [7:0] rdata_q;
    logic       upd_q;

    assign hit   = (bus_addr[IOA_W-1:1] == WIN_BASE[IOA_W-1:1]);
    assign rd_go = bus_rd && !rd_q && hit;
    assign wr_go = bus_wr && !wr_q && hit;

    assign idx_rd = rd_go && !bus_addr[0];
    assign idx_wr = wr_go && !bus_addr[0];
    assign dat_wr = wr_go &&  bus_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rdata_q <= 8'h00;
            upd_q   <= 1'b0;
        end else begin
            rd_q  <= bus_rd;
            wr_q  <= bus_wr;
            upd_q <= accept;
            if (rd_go) rdata_q <= bus_addr[0] ? dat_rdata : idx_rdata;
        end
    end

    sio_cfg_index u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_rd    (idx_rd),
        .idx_wr    (idx_wr),
        .wdata     (bus_wdata),
        .sel_idx   (sel_idx),
        .idx_rdata (idx_rdata)
    );

    sio_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .dat_wr    (dat_wr),
        .sel_idx   (sel_idx),
        .wdata     (bus_wdata),
        .accept    (accept),
        .en_reg    (en_reg),
        .addr_reg  (addr_reg),
        .pwr_reg   (pwr_reg),
        .dat_rdata (dat_rdata)
    );

    sio_cfg_decode #(.IOA_W(IOA_W)) u_decode (
        .en_reg     (en_reg),
        .addr_reg   (addr_reg),
        .par_irq_hi (pwr_reg[3]),
        .par_en     (par_en),
        .par_base   (par_base),
        .par_irq    (par_irq),
        .uart_en    (uart_en),
        .uart_base  (uart_base),
        .uart_irq   (uart_irq),
        .fdc_en     (fdc_en),
        .fdc_quad   (fdc_quad),
        .fdc_base   (fdc_base),
        .fdc_irq    (fdc_irq),
        .ide_en     (ide_en),
        .ide_base   (ide_base),
        .ide_alt    (ide_alt),
        .ide_irq    (ide_irq)
    );

    assign bus_rdata = rdata_q;
    assign cfg_upd   = upd_q;

endmodule

// File: rtl/sio_cfg_unit_chk.sv
module sio_cfg_unit_chk #(
    parameter int IOA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd,
    input logic [7:0]            bus_rdata,
    input logic                  cfg_upd,
    input logic                  par_en,
    input logic [1:0]            uart_en,
    input logic                  fdc_en,
    input logic                  ide_en,
    input logic [IOA_W-1:0]      par_base,
    input logic [3:0]            par_irq,
    input logic [1:0][3:0]       uart_irq
);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd |=> !cfg_upd);

    a_r5_en_change_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({par_en, uart_en, fdc_en, ide_en}) |-> cfg_upd);

    a_r10_rdata_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_rdata) |-> $past(bus_rd));

    a_r7_uart_irq_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ((uart_irq[0] == 4'd3) || (uart_irq[0] == 4'd4)) &&
        ((uart_irq[1] == 4'd3) || (uart_irq[1] == 4'd4)));

    a_r6_alt_parallel_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (par_base == IOA_W'(16'h03BC)) |-> (par_irq == 4'd7));

endmodule

bind sio_cfg_unit sio_cfg_unit_chk #(.IOA_W(IOA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cfg_upd   (cfg_upd),
    .par_en    (par_en),
    .uart_en   (uart_en),
    .fdc_en    (fdc_en),
    .ide_en    (ide_en),
    .par_base  (par_base),
    .par_irq   (par_irq),
    .uart_irq  (uart_irq)
);

// File: tb/sio_cfg_unit_test.sv
module sio_cfg_unit_test;

    localparam int W = 16;
    localparam logic [15:0] IDX = 16'h0398;
    localparam logic [15:0] DAT = 16'h0399;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      strap = 5'd1;
    logic [W-1:0]    bus_addr = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            cfg_upd, par_en, fdc_en, fdc_quad, ide_en;
    logic [W-1:0]    par_base, fdc_base, ide_base, ide_alt;
    logic [3:0]      par_irq, fdc_irq, ide_irq;
    logic [1:0]      uart_en;
    logic [1:0][W-1:0] uart_base;
    logic [1:0][3:0]   uart_irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sio_cfg_unit uut (
        .clk(clk), .rst_n(rst_n), .strap(strap), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_upd(cfg_upd), .par_en(par_en),
        .par_base(par_base), .par_irq(par_irq), .uart_en(uart_en),
        .uart_base(uart_base), .uart_irq(uart_irq), .fdc_en(fdc_en),
        .fdc_quad(fdc_quad), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_alt(ide_alt),
        .ide_irq(ide_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bwr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [15:0] a, input int hold, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        repeat (hold) @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int m_par_base(input logic [7:0] a);
        case (a[1:0])
            2'd0: return 'h378;
            2'd1: return 'h3BC;
            2'd2: return 'h278;
            default: return 0;
        endcase
    endfunction

    function automatic int m_par_irq(input logic [7:0] a, input logic [7:0] p);
        case (a[1:0])
            2'd0: return p[3] ? 7 : 5;
            2'd1: return 7;
            2'd2: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int m_uart_base(input logic [7:0] a, input int n);
        int code;
        int t2 [4] = '{'h3E8, 'h338, 'h2E8, 'h220};
        int t3 [4] = '{'h2E8, 'h238, 'h2E0, 'h228};
        code = (a >> (2 * n + 2)) & 3;
        if (code == 0) return 'h3F8;
        if (code == 1) return 'h2F8;
        if (code == 2) return t2[a[7:6]];
        return t3[a[7:6]];
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        do_reset(5'd1);

        // R3: reset contents on the ports
        chk(bus_rdata == 8'h00 && cfg_upd == 1'b0, "R3 reset outputs", {bus_rdata, 7'd0, cfg_upd}, 0);
        chk(par_en && uart_en == 2'b11 && fdc_en && ide_en && !fdc_quad, "R3/R5 strap1 enables",
            {par_en, uart_en, fdc_en, ide_en}, 5'h1F);

        // R2 / R10: ID sequence, held strobe acts once
        brd(IDX, 1, d); chk(d == 8'h88, "R2 first id read", d, 8'h88);
        brd(IDX, 4, d); chk(d == 8'h00, "R2/R10 second id read held", d, 0);
        bwr(16'h039A, 8'h02);  // R1: outside window, ignored
        brd(IDX, 1, d); chk(d == 8'h00, "R1/R2 selected index after id", d, 0);

        // R3 / R4: register contents for strap 1
        brd(DAT, 1, d); chk(d == 8'h4F, "R3 enable reg strap1", d, 8'h4F);
        bwr(IDX, 8'h01);
        brd(DAT, 3, d); chk(d == 8'h11, "R3/R4 address reg strap1", d, 8'h11);
        bwr(IDX, 8'h02);
        brd(DAT, 1, d); chk(d == 8'h00, "R3/R4 power reg strap1", d, 0);

        // R9: update pulse timing
        bwr(IDX, 8'h00);
        bwr(DAT, 8'h4F);
        chk(cfg_upd == 1'b1, "R9 pulse after accepted write", cfg_upd, 1);
        @(negedge clk);
        chk(cfg_upd == 1'b0, "R9 pulse one cycle", cfg_upd, 0);

        // R4 / R9: indices >= 3 ignored and read zero
        for (int i = 3; i < 256; i++) begin
            bwr(IDX, 8'(i));
            bwr(DAT, 8'h5A);
            chk(cfg_upd == 1'b0, "R9 no pulse on ignored write", cfg_upd, 0);
            brd(DAT, 1, d);
            chk(d == 8'h00, "R4 invalid index read", d, 0);
        end
        bwr(IDX, 8'h00);
        brd(DAT, 1, d); chk(d == 8'h4F, "R4 enable reg untouched", d, 8'h4F);
        bwr(IDX, 8'h01);
        brd(DAT, 1, d); chk(d == 8'h11, "R4 address reg untouched", d, 8'h11);

        // R1: data write outside window ignored
        bwr(16'h0199, 8'hFF);
        brd(DAT, 1, d); chk(d == 8'h11, "R1 out-of-window write", d, 8'h11);

        // R6 / R7: sweep address register with both power bit3 values
        for (int p = 0; p < 2; p++) begin
            bwr(IDX, 8'h02);
            bwr(DAT, p ? 8'h08 : 8'h00);
            bwr(IDX, 8'h01);
            for (int a = 0; a < 256; a++) begin
                bwr(DAT, 8'(a));
                chk(int'(par_base) == m_par_base(8'(a)), "R6 parallel base", par_base, m_par_base(8'(a)));
                chk(int'(par_irq) == m_par_irq(8'(a), p ? 8'h08 : 8'h00), "R6 parallel irq",
                    par_irq, m_par_irq(8'(a), p ? 8'h08 : 8'h00));
                for (int n = 0; n < 2; n++) begin
                    chk(int'(uart_base[n]) == m_uart_base(8'(a), n), "R7 uart base",
                        uart_base[n], m_uart_base(8'(a), n));
                    chk(int'(uart_irq[n]) == ((((a >> (2 * n + 2)) & 1) != 0) ? 3 : 4), "R7 uart irq",
                        uart_irq[n], ((((a >> (2 * n + 2)) & 1) != 0) ? 3 : 4));
                end
            end
        end

        // R5 / R8: sweep enable register
        bwr(IDX, 8'h00);
        for (int e = 0; e < 256; e++) begin
            bwr(DAT, 8'(e));
            chk({par_en, uart_en, fdc_en, fdc_quad, ide_en} ==
                {e[0], e[2], e[1], e[3], e[4], e[6]}, "R5 enable bits",
                {par_en, uart_en, fdc_en, fdc_quad, ide_en}, {e[0], e[2], e[1], e[3], e[4], e[6]});
            chk(int'(fdc_base) == (e[5] ? 'h370 : 'h3F0) && fdc_irq == 4'd6, "R8 floppy base/irq",
                fdc_base, e[5] ? 'h370 : 'h3F0);
            chk(int'(ide_base) == (e[7] ? 'h170 : 'h1F0) && int'(ide_alt) == (e[7] ? 'h376 : 'h3F6)
                && ide_irq == 4'd14, "R8 ide base/alt/irq", ide_base, e[7] ? 'h170 : 'h1F0);
        end

        // R3: strap 31, and R2: index write ends ID sequence
        do_reset(5'd31);
        chk(!par_en && uart_en == 2'b00 && !fdc_en && !ide_en, "R3 strap31 enables off",
            {par_en, uart_en, fdc_en, ide_en}, 0);
        bwr(IDX, 8'h02);
        brd(IDX, 1, d); chk(d == 8'h02, "R2 write ends id sequence", d, 2);
        brd(DAT, 1, d); chk(d == 8'h02, "R3 power reg strap31", d, 2);
        bwr(IDX, 8'h01);
        brd(DAT, 1, d); chk(d == 8'h10, "R3 address reg strap31", d, 8'h10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule